// File: doc/BRIEF.md
# Wavefront Divergence Lane-Mask Controller

This block keeps the lane-activity mask of a single wavefront running on a vector core that has one program counter for all lanes. Divergent if/else code is executed by narrowing that mask instead of branching per lane. The vector ALU writes a per-lane comparison result into a condition register. The scalar sequencer then issues decoded mask operations: push the live mask onto a save stack, intersect the live mask with the condition, invert the live mask against the saved one for the else-side, and pop the saved mask back at the join point.

Two combinational flags let the branch logic skip a whole body. One flag is raised when the condition register is all zero, and the other when the live mask is all zero. Every lane's register-file write enable is the live mask gated by the current vector write request, so inactive lanes keep their old values. An eight-deep stack of saved masks allows conditionals to nest. A push onto a full stack, or a pop or else-inversion on an empty stack, sets a sticky error flag and changes nothing else.

The interface is plain control: one operation code per cycle, plus an optional compare write. There is no valid/ready handshake and no back-pressure. Every operation completes in the cycle it is presented.

Top module: `lane_mask_ctrl`

## Requirements
- R1: After reset the live mask is all ones, the condition register is zero, the stack is empty and the error flag is 0; as a result cond_zero is 1 and exec_zero is 0.
- R2: When cmp_valid is 1 at a clock edge, the condition register takes cmp_bits at that edge; otherwise it holds.
- R3: op_code 1 (save) pushes the live mask onto the stack and leaves the live mask unchanged.
- R4: op_code 2 (narrow) sets the live mask to condition AND live mask. It uses the condition value held before that edge, even when a compare write arrives in the same cycle.
- R5: cond_zero is 1 exactly when the condition register is all zero, and is valid in the cycle after the compare write.
- R6: op_code 3 (flip) sets the live mask to top-of-stack AND NOT live mask and leaves the stack unchanged.
- R7: exec_zero is 1 exactly when the live mask is all zero, and is valid in the cycle after the mask write.
- R8: op_code 4 (restore) sets the live mask to the top-of-stack entry and removes that entry.
- R9: lane_wr_en bit i is 1 only when vec_wr_req is 1 and live-mask bit i is 1 (combinational).
- R10: The stack holds up to 8 masks and returns them in last-in, first-out order.
- R11: A save with 8 entries stored, or a restore or flip with none stored, sets stack_err; the live mask and the stack stay unchanged; stack_err stays 1 until reset.
- R12: op_code 0 and op_codes 5, 6 and 7 leave the live mask and the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Load cmp_bits into the condition register |
| cmp_bits | input | 64 | Per-lane compare result |
| op_code | input | 3 | Mask operation: 0 none, 1 save, 2 narrow, 3 flip, 4 restore |
| vec_wr_req | input | 1 | The current vector instruction writes its destination |
| exec_mask | output | 64 | Live lane mask |
| lane_wr_en | output | 64 | Per-lane register-file write enable |
| cond_zero | output | 1 | Condition register is all zero |
| exec_zero | output | 1 | Live mask is all zero |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
On every cycle the assertions check the following:
- the compare load into the condition register, and the cond_zero response;
- the narrow and save updates of the live mask;
- that write enables never reach a lane whose mask bit is 0;
- that overflow and underflow set a flag that then persists, with the live mask frozen;
- that unused op codes have no effect.

Only the bench scenarios can show that saved masks come back in LIFO order through eight levels of nesting. The same holds for the full if/else/join sequence, for the ordering when a compare and a narrow fall in the same cycle, and for long random operation mixes checked against a reference model.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_NONE    = 3'd0;
  localparam logic [OP_W-1:0] OP_SAVE    = 3'd1;
  localparam logic [OP_W-1:0] OP_NARROW  = 3'd2;
  localparam logic [OP_W-1:0] OP_FLIP    = 3'd3;
  localparam logic [OP_W-1:0] OP_RESTORE = 3'd4;
endpackage

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LANES-1:0] push_data,
  output logic [LANES-1:0] top_data,
  output logic             full,
  output logic             empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0]    cnt;
  logic [LANES-1:0] slot [DEPTH];
  logic [IW-1:0]    wr_idx;
  logic [IW-1:0]    rd_idx;

  assign wr_idx = IW'(cnt);
  assign rd_idx = IW'(cnt - CW'(1));
  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign top_data = empty ? '0 : slot[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (pop)  cnt <= cnt - CW'(1);
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot[gi] <= '0;
      else if (push && wr_idx == IW'(gi))  slot[gi] <= push_data;
    end
  end
endmodule

// File: rtl/lane_mask_update.sv
module lane_mask_update
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic [OP_W-1:0]  op,
  input  logic [LANES-1:0] exec_cur,
  input  logic [LANES-1:0] cond_cur,
  input  logic [LANES-1:0] top_cur,
  input  logic             stk_full,
  input  logic             stk_empty,
  output logic [LANES-1:0] exec_nxt,
  output logic             do_push,
  output logic             do_pop,
  output logic             fault
);
  always_comb begin
    exec_nxt = exec_cur;
    do_push  = 1'b0;
    do_pop   = 1'b0;
    fault    = 1'b0;
    unique case (op)
      OP_SAVE: begin
        if (stk_full) fault = 1'b1;
        else          do_push = 1'b1;
      end
      OP_NARROW: exec_nxt = cond_cur & exec_cur;
      OP_FLIP: begin
        if (stk_empty) fault = 1'b1;
        else           exec_nxt = top_cur & ~exec_cur;
      end
      OP_RESTORE: begin
        if (stk_empty) fault = 1'b1;
        else begin
          exec_nxt = top_cur;
          do_pop   = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic [LANES-1:0] cmp_bits,
  input  logic [2:0]       op_code,
  input  logic             vec_wr_req,
  output logic [LANES-1:0] exec_mask,
  output logic [LANES-1:0] lane_wr_en,
  output logic             cond_zero,
  output logic             exec_zero,
  output logic             stack_err
);
  logic [LANES-1:0] exec_q, cond_q, exec_nxt, top_mask;
  logic             push, pop, fault, full, empty, err_q;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_data(exec_q), .top_data(top_mask), .full(full), .empty(empty)
  );

  lane_mask_update #(.LANES(LANES)) u_update (
    .op(op_code), .exec_cur(exec_q), .cond_cur(cond_q), .top_cur(top_mask),
    .stk_full(full), .stk_empty(empty), .exec_nxt(exec_nxt),
    .do_push(push), .do_pop(pop), .fault(fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= '1;
      cond_q <= '0;
      err_q  <= 1'b0;
    end else begin
      exec_q <= exec_nxt;
      if (cmp_valid) cond_q <= cmp_bits;
      if (fault)     err_q  <= 1'b1;
    end
  end

  assign exec_mask  = exec_q;
  assign lane_wr_en = exec_q & {LANES{vec_wr_req}};
  assign cond_zero  = (cond_q == '0);
  assign exec_zero  = (exec_q == '0);
  assign stack_err  = err_q;
endmodule

// File: rtl/lane_mask_chk.sv
module lane_mask_chk
  import lane_mask_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_valid,
  input logic [LANES-1:0] cmp_bits,
  input logic [2:0]       op_code,
  input logic [LANES-1:0] exec_mask,
  input logic [LANES-1:0] lane_wr_en,
  input logic [LANES-1:0] cond_reg,
  input logic             cond_zero,
  input logic             exec_zero,
  input logic             stack_err
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] depth_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_seen <= '0;
    else if (op_code == OP_SAVE && depth_seen != CW'(DEPTH)) depth_seen <= depth_seen + CW'(1);
    else if (op_code == OP_RESTORE && depth_seen != '0)      depth_seen <= depth_seen - CW'(1);
  end

  AST_COND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> cond_reg == $past(cmp_bits)); // R2
  AST_SAVE_KEEPS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == OP_SAVE |=> $stable(exec_mask)); // R3
  AST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    op_code == OP_NARROW |=> exec_mask == ($past(exec_mask) & $past(cond_reg))); // R4
  AST_COND_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_bits == '0) |=> cond_zero); // R5
  AST_IDLE_LANES_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_zero |-> lane_wr_en == '0); // R7
  AST_WE_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_wr_en & ~exec_mask) == '0); // R9
  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_SAVE && depth_seen == CW'(DEPTH)) |=> stack_err); // R11
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_code == OP_RESTORE || op_code == OP_FLIP) && depth_seen == '0)
      |=> stack_err && $stable(exec_mask)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err); // R11
  AST_UNUSED_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_NONE || op_code > OP_RESTORE) |=> $stable(exec_mask)); // R12
endmodule

bind lane_mask_ctrl lane_mask_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_bits(cmp_bits),
  .op_code(op_code), .exec_mask(exec_mask), .lane_wr_en(lane_wr_en),
  .cond_reg(cond_q), .cond_zero(cond_zero), .exec_zero(exec_zero),
  .stack_err(stack_err)
);

// File: tb/lane_mask_ctrl_bench.sv
`timescale 1ns/1ps
module lane_mask_ctrl_bench;
  localparam int LANES = 64;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmp_valid = 1'b0;
  logic [LANES-1:0] cmp_bits = '0;
  logic [2:0]       op_code = 3'd0;
  logic             vec_wr_req = 1'b0;
  logic [LANES-1:0] exec_mask, lane_wr_en;
  logic             cond_zero, exec_zero, stack_err;

  lane_mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_lane_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_bits(cmp_bits),
    .op_code(op_code), .vec_wr_req(vec_wr_req), .exec_mask(exec_mask),
    .lane_wr_en(lane_wr_en), .cond_zero(cond_zero), .exec_zero(exec_zero),
    .stack_err(stack_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [LANES-1:0] m_exec, m_cond;
  logic [LANES-1:0] m_stk [DEPTH];
  int               m_depth;
  bit               m_err;

  task automatic chk(string tag, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_exec = '1; m_cond = '0; m_depth = 0; m_err = 1'b0;
  endtask

  task automatic model_step(logic [2:0] op, bit cv, logic [LANES-1:0] cb);
    case (op)
      3'd1: if (m_depth == DEPTH) m_err = 1'b1;
            else begin m_stk[m_depth] = m_exec; m_depth++; end
      3'd2: m_exec = m_cond & m_exec;
      3'd3: if (m_depth == 0) m_err = 1'b1;
            else m_exec = m_stk[m_depth-1] & ~m_exec;
      3'd4: if (m_depth == 0) m_err = 1'b1;
            else begin m_depth--; m_exec = m_stk[m_depth]; end
      default: ;
    endcase
    if (cv) m_cond = cb;
  endtask

  task automatic check_state(string tag);
    chk({tag, " exec_mask"}, exec_mask, m_exec);
    chk({tag, " R5 cond_zero"}, LANES'(cond_zero), LANES'(m_cond == '0));
    chk({tag, " R7 exec_zero"}, LANES'(exec_zero), LANES'(m_exec == '0));
    chk({tag, " R11 stack_err"}, LANES'(stack_err), LANES'(m_err));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(logic [2:0] op, bit cv, logic [LANES-1:0] cb, bit vw, string tag);
    op_code = op; cmp_valid = cv; cmp_bits = cb; vec_wr_req = vw;
    #1;
    chk({tag, " R9 lane_wr_en"}, lane_wr_en, vw ? m_exec : '0);
    @(posedge clk);
    model_step(op, cv, cb);
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_code = 3'd0; cmp_valid = 1'b0; vec_wr_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [LANES-1:0] pat, pat2;
    logic [LANES-1:0] pushed [DEPTH];
    void'($urandom(32'd20130603));
    do_reset();
    // R1 reset state
    chk("R1 exec all ones", exec_mask, '1);
    chk("R1 cond_zero", LANES'(cond_zero), LANES'(1));
    chk("R1 exec_zero", LANES'(exec_zero), LANES'(0));
    chk("R1 stack_err", LANES'(stack_err), LANES'(0));

    // if/else/join sequence: R2 R3 R4 R6 R8
    pat = 64'hF0F0_1234_00FF_A5A5;
    cyc(3'd0, 1'b1, pat, 1'b0, "R2 compare load");
    cyc(3'd1, 1'b0, '0, 1'b1, "R3 save");
    cyc(3'd2, 1'b0, '0, 1'b1, "R4 narrow");
    chk("R4 exec after narrow", exec_mask, pat);
    cyc(3'd3, 1'b0, '0, 1'b1, "R6 flip");
    chk("R6 exec after flip", exec_mask, ~pat);
    cyc(3'd4, 1'b0, '0, 1'b1, "R8 restore");
    chk("R8 exec after restore", exec_mask, '1);

    // all-zero condition: R5 R7 R9
    cyc(3'd0, 1'b1, '0, 1'b0, "R5 zero compare");
    cyc(3'd1, 1'b0, '0, 1'b0, "R3 save");
    cyc(3'd2, 1'b0, '0, 1'b1, "R7 narrow to zero");
    cyc(3'd0, 1'b0, '0, 1'b1, "R9 no lane writes when idle");
    cyc(3'd3, 1'b0, '0, 1'b0, "R6 flip to all");
    cyc(3'd4, 1'b0, '0, 1'b0, "R8 restore");

    // narrow and compare in one cycle uses the older condition: R4
    pat2 = 64'h0000_FFFF_0000_0F0F;
    cyc(3'd0, 1'b1, pat, 1'b0, "R2 load");
    cyc(3'd2, 1'b1, pat2, 1'b0, "R4 same-cycle compare");
    chk("R4 older condition used", exec_mask, pat);
    cyc(3'd4, 1'b0, '0, 1'b0, "R11 restore on empty");
    do_reset();

    // nesting and LIFO order: R10, then overflow R11
    for (int i = 0; i < DEPTH; i++) begin
      pushed[i] = m_exec;
      cyc(3'd1, 1'b1, ~(64'h1 << (i * 7)), 1'b0, "R10 nested save");
      cyc(3'd2, 1'b0, '0, 1'b0, "R10 nested narrow");
    end
    pat = m_exec;
    cyc(3'd1, 1'b0, '0, 1'b0, "R11 overflow");
    chk("R11 overflow sets flag", LANES'(stack_err), LANES'(1));
    chk("R11 overflow keeps exec", exec_mask, pat);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      cyc(3'd4, 1'b0, '0, 1'b0, "R10 nested restore");
      chk("R10 LIFO order", exec_mask, pushed[i]);
    end
    cyc(3'd4, 1'b0, '0, 1'b0, "R11 underflow restore");
    chk("R11 flag sticky", LANES'(stack_err), LANES'(1));
    do_reset();
    cyc(3'd3, 1'b0, '0, 1'b0, "R11 flip on empty");
    chk("R11 flip on empty keeps exec", exec_mask, '1);
    do_reset();

    // unused op codes: R12
    cyc(3'd0, 1'b1, pat2, 1'b0, "R12 load");
    cyc(3'd2, 1'b0, '0, 1'b0, "R12 narrow");
    for (int c = 5; c < 8; c++) cyc(3'(c), 1'b0, '0, 1'b1, "R12 unused op");
    cyc(3'd0, 1'b0, '0, 1'b1, "R12 none op");
    cyc(3'd4, 1'b0, '0, 1'b0, "R12 stack untouched");
    chk("R12 stack still empty", LANES'(stack_err), LANES'(1));

    // constrained random mix against the model
    for (int blk = 0; blk < 10; blk++) begin
      do_reset();
      for (int n = 0; n < 300; n++) begin
        int sel;
        logic [2:0] op;
        logic [LANES-1:0] cb;
        sel = $urandom_range(0, 99);
        if (sel < 25)      op = 3'd1;
        else if (sel < 45) op = 3'd2;
        else if (sel < 60) op = 3'd3;
        else if (sel < 85) op = 3'd4;
        else               op = 3'($urandom_range(0, 7));
        sel = $urandom_range(0, 9);
        cb = (sel == 0) ? '0 : (sel == 1) ? '1 : {$urandom, $urandom};
        cyc(op, $urandom_range(0, 1) == 1, cb, $urandom_range(0, 1) == 1,
            "R10 random mix");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule